// File: doc/BRIEF.md
# Serial Receiver with Per-Character Status FIFO

This block is the receive half of an asynchronous serial port. It watches a single idle-high line, locks onto falling edges that survive a mid-bit check, shifts in eight data bits least significant bit first, optionally takes one parity bit, and then samples one stop bit. Each finished character goes into a short FIFO. The FIFO stores the character together with its own parity-error and frame-error bits, so a status flag always describes the character that sits beside it.

Bit timing comes from a `sample_tick` strobe that the surrounding logic pulses sixteen times per bit period. Three control levels set the behaviour. `parity_on` inserts and checks a parity bit, `parity_odd` chooses odd or even parity, and `rx_enable` turns the receiver on. Dropping `rx_enable` ends any frame in progress at once and discards every stored character. A consumer sees the oldest character and its flags on the read side, and pulses `rd_pop` to move on to the next one.

Top module: `serial_rx_fifo`

## Requirements
- R1: The line passes through a two-flop synchronizer. A falling edge counts as a start bit only if the line is still low on the 8th sample tick after the edge. A low pulse shorter than half a bit produces no character.
- R2: Eight data bits are taken least significant bit first, each sampled 16 ticks after the previous sample point. The received byte appears unchanged on `rd_data`.
- R3: With `parity_on` = 1, one parity bit follows the eighth data bit. `rd_parity_err` of that character is 1 when the XOR of the data bits, the parity bit and `parity_odd` is 1. With `parity_odd` = 0 the check is even parity, with `parity_odd` = 1 it is odd parity.
- R4: With `parity_on` = 0 when a frame's start bit is validated, that frame has no parity bit, and its stored parity-error bit is 0.
- R5: A stop bit sampled low stores frame-error = 1 with that character. A stop bit sampled high stores 0.
- R6: `rd_valid` is 1 exactly when the FIFO holds at least one character. While `rd_valid` is 0, `rd_data`, `rd_parity_err` and `rd_frame_err` read 0. A `rd_pop` with `rd_valid` = 1 removes the head, and the next character with its own flags appears in the following cycle.
- R7: The FIFO holds 2 characters. A character that completes while the FIFO is full and no pop is made in that cycle is dropped, and `overrun` goes to 1. `overrun` clears on the next accepted pop or when `rx_enable` is 0.
- R8: With `rx_enable` = 0, the FIFO is emptied on the next clock edge and a frame in progress is abandoned. No part of that frame is stored.
- R9: While `rd_valid` = 1 and no pop is made, the head character and its flags stay unchanged.
- R10: After reset, `rd_valid`, `rd_data`, `rd_parity_err`, `rd_frame_err` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_tick | input | 1 | One-cycle strobe, 16 per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_enable | input | 1 | Receiver on; 0 aborts the current frame and flushes the FIFO |
| parity_on | input | 1 | Frames carry and check a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_pop | input | 1 | Remove the head character |
| rd_data | output | 8 | Head character |
| rd_valid | output | 1 | FIFO not empty |
| rd_parity_err | output | 1 | Parity error of the head character |
| rd_frame_err | output | 1 | Frame error of the head character |
| overrun | output | 1 | A completed character was dropped because the FIFO was full |

## Verification
The checker watches the read side on every cycle. It confirms that the FIFO is empty and `overrun` is clear after a disabled cycle, and that the head character and its flags hold still until a pop. It also confirms that an empty FIFO shows zero flags and that `overrun` can only rise while data is waiting. Bit ordering, the parity arithmetic for both senses, the frame-error capture, rejection of short glitches and the abort of a half-received frame all depend on the serial waveform. Only the bench's frames can show these, so the bench compares each received character and its flags against values computed from the bytes it sent.

// File: rtl/srx_pkg.sv
// Package: shared types for the serial receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package srx_pkg;

    // Receive frame sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } rx_phase_t;

endpackage

// File: rtl/srx_sync.sv
// Module: two-flop synchronizer for the serial input.
// Assumes: the line idles high, so both flops reset to 1.
module srx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;
    logic sync_q;

    // Capture the asynchronous line through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/srx_deser.sv
// Module: frame sequencer. Finds a start bit, samples the data bits at
//         bit centres, then the optional parity bit and one stop bit, and
//         emits one push pulse per completed character.
// Assumes: sample_tick pulses OSR times per bit. The line is already
//          synchronized. Parity settings are latched at start validation.
module srx_deser
    import srx_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 tick,
    input  logic                 rx,
    input  logic                 parity_on,
    input  logic                 parity_odd,
    output logic                 push,
    output logic [DATA_BITS-1:0] push_data,
    output logic                 push_perr,
    output logic                 push_ferr
);
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned BIT_W = $clog2(DATA_BITS + 1);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

    rx_phase_t             phase_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [BIT_W-1:0]      bit_q;
    logic [DATA_BITS-1:0]  shift_q;
    logic                  par_en_q;
    logic                  par_odd_q;
    logic                  perr_q;

    // Step the frame sequencer on each sample tick
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            bit_q     <= '0;
            shift_q   <= '0;
            par_en_q  <= 1'b0;
            par_odd_q <= 1'b0;
            perr_q    <= 1'b0;
            push      <= 1'b0;
            push_data <= '0;
            push_perr <= 1'b0;
            push_ferr <= 1'b0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                unique case (phase_q)
                    PH_IDLE: begin
                        if (!rx) begin
                            phase_q <= PH_START;
                            cnt_q   <= '0;
                        end
                    end
                    PH_START: begin
                        if (cnt_q == MID_CNT) begin
                            cnt_q <= '0;
                            if (!rx) begin
                                phase_q   <= PH_DATA;
                                bit_q     <= '0;
                                perr_q    <= 1'b0;
                                par_en_q  <= parity_on;
                                par_odd_q <= parity_odd;
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (cnt_q == LAST_CNT) begin
                            cnt_q   <= '0;
                            shift_q <= {rx, shift_q[DATA_BITS-1:1]};
                            bit_q   <= bit_q + 1'b1;
                            if (bit_q == LAST_BIT)
                                phase_q <= par_en_q ? PH_PARITY : PH_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_PARITY: begin
                        if (cnt_q == LAST_CNT) begin
                            cnt_q   <= '0;
                            perr_q  <= (^shift_q) ^ rx ^ par_odd_q;
                            phase_q <= PH_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        if (cnt_q == LAST_CNT) begin
                            cnt_q     <= '0;
                            push      <= 1'b1;
                            push_data <= shift_q;
                            push_perr <= par_en_q & perr_q;
                            push_ferr <= ~rx;
                            phase_q   <= PH_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_fifo.sv
// Module: small FIFO of characters, each stored with its parity and frame
//         error bits. Shows the head entry and drops pushes when full.
// Assumes: DEPTH >= 2. flush empties it in one cycle.
module srx_fifo #(
    parameter int unsigned WIDTH = 10,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_word,
    input  logic             pop,
    output logic [WIDTH-1:0] head_word,
    output logic             not_empty,
    output logic             overrun
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] rptr_q;
    logic [CNT_W-1:0] count_q;
    logic             pop_ok;
    logic             push_ok;

    // Decide which requests take effect this cycle
    always_comb begin
        pop_ok  = pop && (count_q != '0);
        push_ok = push && ((count_q != FULL_CNT) || pop_ok);
    end

    // Store accepted characters
    always_ff @(posedge clk) begin
        if (push_ok && !flush)
            mem_q[wptr_q] <= push_word;
    end

    // Move the pointers, the occupancy and the overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok)
                wptr_q <= (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
            if (pop_ok)
                rptr_q <= (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
            if (push_ok && !pop_ok)
                count_q <= count_q + 1'b1;
            else if (pop_ok && !push_ok)
                count_q <= count_q - 1'b1;
            if (push && !push_ok)
                overrun <= 1'b1;
            else if (pop_ok)
                overrun <= 1'b0;
        end
    end

    assign not_empty = (count_q != '0);
    assign head_word = not_empty ? mem_q[rptr_q] : '0;
endmodule

// File: rtl/serial_rx_fifo.sv
// Module: top of the serial receive path. Chains the synchronizer, the
//         frame sequencer and the per-character status FIFO.
// Assumes: sample_tick is OSR strobes per bit. rx_enable low aborts and flushes.
module serial_rx_fifo #(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned OSR       = 16,
    parameter int unsigned DEPTH     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_tick,
    input  logic                 rx_line,
    input  logic                 rx_enable,
    input  logic                 parity_on,
    input  logic                 parity_odd,
    input  logic                 rd_pop,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 rd_valid,
    output logic                 rd_parity_err,
    output logic                 rd_frame_err,
    output logic                 overrun
);
    localparam int unsigned WORD_W = DATA_BITS + 2;

    logic                 rx_sync;
    logic                 push;
    logic [DATA_BITS-1:0] push_data;
    logic                 push_perr;
    logic                 push_ferr;
    logic [WORD_W-1:0]    head_word;

    srx_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (rx_sync)
    );

    srx_deser #(
        .DATA_BITS (DATA_BITS),
        .OSR       (OSR)
    ) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_enable),
        .tick       (sample_tick),
        .rx         (rx_sync),
        .parity_on  (parity_on),
        .parity_odd (parity_odd),
        .push       (push),
        .push_data  (push_data),
        .push_perr  (push_perr),
        .push_ferr  (push_ferr)
    );

    srx_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!rx_enable),
        .push      (push),
        .push_word ({push_ferr, push_perr, push_data}),
        .pop       (rd_pop),
        .head_word (head_word),
        .not_empty (rd_valid),
        .overrun   (overrun)
    );

    assign rd_data       = head_word[DATA_BITS-1:0];
    assign rd_parity_err = head_word[DATA_BITS];
    assign rd_frame_err  = head_word[DATA_BITS+1];
endmodule

// File: rtl/serial_rx_fifo_checker.sv
// Module: cycle-level properties of the read side of serial_rx_fifo.
// Assumes: bound to every instance of the top module.
module serial_rx_fifo_checker #(
    parameter int unsigned DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_enable,
    input logic                 rd_pop,
    input logic [DATA_BITS-1:0] rd_data,
    input logic                 rd_valid,
    input logic                 rd_parity_err,
    input logic                 rd_frame_err,
    input logic                 overrun
);
    assert_flush_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (!rd_valid && !overrun));

    assert_empty_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0 && !rd_parity_err && !rd_frame_err));

    assert_entry_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && rd_valid && !rd_pop) |=> rd_valid);

    assert_head_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && rd_valid && !rd_pop) |=>
            ($stable(rd_data) && $stable(rd_parity_err) && $stable(rd_frame_err)));

    assert_overrun_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rd_valid));
endmodule

bind serial_rx_fifo serial_rx_fifo_checker #(.DATA_BITS(DATA_BITS)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_enable     (rx_enable),
    .rd_pop        (rd_pop),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .rd_parity_err (rd_parity_err),
    .rd_frame_err  (rd_frame_err),
    .overrun       (overrun)
);

// File: tb/serial_rx_fifo_test.sv
// Bench: random frames under a fixed seed, plus directed corner cases.
module serial_rx_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OSR        = 16;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b0;
    logic       parity_on = 1'b0;
    logic       parity_odd = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       rd_parity_err;
    logic       rd_frame_err;
    logic       overrun;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int tick_cnt = 0;

    serial_rx_fifo uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_tick   (sample_tick),
        .rx_line       (rx_line),
        .rx_enable     (rx_enable),
        .parity_on     (parity_on),
        .parity_odd    (parity_odd),
        .rd_pop        (rd_pop),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid),
        .rd_parity_err (rd_parity_err),
        .rd_frame_err  (rd_frame_err),
        .overrun       (overrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Free-running oversample strobe, changed away from the active edge
    always @(negedge clk) begin
        tick_cnt    <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        sample_tick <= (tick_cnt == TICK_DIV - 1);
    end

    function automatic bit exp_perr(input logic [7:0] d, input bit use_par,
                                    input bit pbit, input bit odd);
        return use_par && ((^d) ^ pbit ^ odd);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hold_bit(input bit b);
        rx_line = b;
        repeat (OSR * TICK_DIV) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit use_par,
                              input bit pbit, input bit stopb);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        if (use_par) hold_bit(pbit);
        hold_bit(stopb);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R10: reset values
        check("R10", "valid", 32'(rd_valid), 0);
        check("R10", "data", 32'(rd_data), 0);
        check("R10", "perr", 32'(rd_parity_err), 0);
        check("R10", "ferr", 32'(rd_frame_err), 0);
        check("R10", "overrun", 32'(overrun), 0);
        rst_n = 1'b1;
        rx_enable = 1'b1;
        repeat (4) @(negedge clk);

        // R2 directed: asymmetric pattern shows bit order
        send_frame(8'h01, 1'b0, 1'b0, 1'b1);
        check("R2", "lsb first data", 32'(rd_data), 32'h01);
        check("R4", "no parity err", 32'(rd_parity_err), 0);
        pop_one();
        check("R6", "empty after pop", 32'(rd_valid), 0);

        // R1: short low glitch yields no character
        hold_bit(1'b1);
        rx_line = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * OSR * TICK_DIV) @(negedge clk);
        check("R1", "glitch ignored", 32'(rd_valid), 0);

        // R3/R4/R5 random frames
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d;
            bit up, od, bad_par, bad_stop, pb;
            d        = 8'($urandom);
            up       = 1'($urandom);
            od       = 1'($urandom);
            bad_par  = ($urandom % 3) == 0;
            bad_stop = ($urandom % 5) == 0;
            pb       = (^d) ^ od ^ bad_par;
            parity_on  = up;
            parity_odd = od;
            send_frame(d, up, pb, !bad_stop);
            check("R2", "random data", 32'(rd_data), 32'(d));
            check("R3", "parity flag", 32'(rd_parity_err), 32'(exp_perr(d, up, pb, od)));
            check("R5", "frame flag", 32'(rd_frame_err), 32'(bad_stop));
            pop_one();
            check("R6", "drained", 32'(rd_valid), 0);
        end

        // R7/R9: fill, overflow, drain with per-entry flags
        parity_on  = 1'b1;
        parity_odd = 1'b0;
        send_frame(8'hA5, 1'b1, 1'b1, 1'b1);
        send_frame(8'h3C, 1'b1, 1'b0, 1'b0);
        check("R7", "no overrun at two", 32'(overrun), 0);
        send_frame(8'h77, 1'b1, 1'b0, 1'b1);
        check("R7", "overrun set", 32'(overrun), 1);
        check("R9", "head kept", 32'(rd_data), 32'hA5);
        check("R3", "head perr even", 32'(rd_parity_err), 1);
        pop_one();
        check("R7", "overrun cleared by pop", 32'(overrun), 0);
        check("R6", "second data", 32'(rd_data), 32'h3C);
        check("R6", "second perr", 32'(rd_parity_err), 0);
        check("R5", "second ferr", 32'(rd_frame_err), 1);
        pop_one();
        check("R7", "dropped char absent", 32'(rd_valid), 0);

        // R8: flush of stored data
        parity_on = 1'b0;
        send_frame(8'h11, 1'b0, 1'b0, 1'b1);
        send_frame(8'h22, 1'b0, 1'b0, 1'b1);
        check("R6", "two stored", 32'(rd_valid), 1);
        rx_enable = 1'b0;
        @(negedge clk);
        rx_enable = 1'b1;
        check("R8", "flushed", 32'(rd_valid), 0);

        // R8: abort a frame in progress
        hold_bit(1'b0);
        hold_bit(1'b0);
        hold_bit(1'b1);
        rx_enable = 1'b0;
        rx_line   = 1'b1;
        repeat (4) @(negedge clk);
        rx_enable = 1'b1;
        repeat (12 * OSR * TICK_DIV) @(negedge clk);
        check("R8", "aborted frame not stored", 32'(rd_valid), 0);

        // R3 odd parity directed, correct bit
        parity_on  = 1'b1;
        parity_odd = 1'b1;
        send_frame(8'h03, 1'b1, 1'b1, 1'b1);
        check("R3", "odd parity ok", 32'(rd_parity_err), 0);
        pop_one();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule